// File: doc/BRIEF.md
# Watchdog Timer with Lockable Overflow Action

This block is a watchdog for a small microcontroller. A binary counter advances on every cycle of the fast clock, or on each enable pulse of a slow time base. When the counter passes the tap chosen by a 2-bit period field, the block acts. Which action it takes is set once after reset: either a one-cycle request for a system reset, or a sticky interrupt that makes the block a periodic tick source. Software keeps a running watchdog from firing by writing a clear code to a command register. Stopping the watchdog takes two steps: clear the enable bit in the control register, then write a disable code to the command register.

The block has a byte-wide write bus with a combinational read port. The control register sits at offset 0x34 and the command register at offset 0x35. The fast and slow clock sources are modelled as one clock plus a slow-tick enable and a source-select input.

Top module: `wdog_top`

## Requirements
- R1: After reset the control register (offset 0x34) reads 0x08: enable bit 3 = 1, action bit 2 = 0 (reset request), period field bits 1:0 = 00. Both outputs are low.
- R2: With `slow_mode` low the counter advances every cycle. With period field s, an overflow occurs every 2^(HI_MAX-2s) cycles, which is 2^23, 2^21, 2^19 or 2^17 at the default parameters.
- R3: With `slow_mode` high the counter advances only on cycles with `slow_tick` high, and overflows every 2^(LO_MAX-2s) ticks (2^15 down to 2^9 at the defaults). A change of `slow_mode` clears the counter.
- R4: The first write to offset 0x34 after reset loads action bit 2 (0 = reset request, 1 = interrupt) and locks it. Later writes leave that bit unchanged until the next reset, while enable and period still update.
- R5: In reset-request mode each overflow drives `wdt_rst_req` high for exactly one cycle, one cycle after the overflowing count, and `wdt_irq` stays low.
- R6: In interrupt mode each overflow sets `wdt_irq`. It stays high until a cycle with `irq_ack` high clears it. An overflow in the same cycle as the acknowledge wins. `wdt_rst_req` stays low.
- R7: Writing 0x4E to offset 0x35 restarts the count from zero. Any value other than 0x4E and 0xB1 written there has no effect.
- R8: Writing 0xB1 to offset 0x35 stops the watchdog only when enable bit 3 already reads 0. A stopped watchdog never overflows. Clearing the enable bit alone leaves it running. Writing enable = 1 restarts a stopped watchdog from a zero count.
- R9: A write to offset 0x34 that changes the period field restarts the count from zero.
- R10: Offset 0x35 reads as 0x00, and the control register reads back as {4'b0, enable, action, period}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (fast source) |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_mode | input | 1 | 1 = count slow-tick pulses, 0 = count every cycle |
| slow_tick | input | 1 | One-cycle enable from the slow time base |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_ack | input | 1 | Clears the interrupt flag |
| wdt_rst_req | output | 1 | One-cycle reset request |
| wdt_irq | output | 1 | Sticky interrupt request |

## Verification
A wrong counter or tap choice shows up as overflow pulses spaced differently from the expected power of two. This is visible at the first or second overflow after any clear. A damaged write-once latch or disable interlock shows at once in the control readback, or as a pulse that should have been absent or a missing one, within one period. A cycle-exact reference model runs beside the design and compares both outputs and the read data on every cycle. Independent counters also measure the pulse spacing.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic {
        ACT_RESET = 1'b0,
        ACT_IRQ   = 1'b1
    } act_e;

    localparam logic [7:0] CMD_CLEAR   = 8'h4E;
    localparam logic [7:0] CMD_DISABLE = 8'hB1;

    localparam int EN_BIT  = 3;
    localparam int ACT_BIT = 2;

    typedef struct packed {
        logic       en;
        act_e       act;
        logic       lock;
        logic [1:0] sel;
        logic       active;
    } ctrl_s;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic [7:0]  CTRL_OFS = 8'h34,
    parameter logic [7:0]  CMD_OFS  = 8'h35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              en,
    output act_e              act,
    output logic [1:0]        sel,
    output logic              active,
    output logic              clear
);

    ctrl_s st_d, st_q;
    logic  wr_ctrl, wr_cmd;

    always_comb begin
        wr_ctrl = we && (addr == ADDR_W'(CTRL_OFS));
        wr_cmd  = we && (addr == ADDR_W'(CMD_OFS));
        st_d    = st_q;
        clear   = 1'b0;
        if (wr_ctrl) begin
            st_d.en  = wdata[EN_BIT];
            st_d.sel = wdata[1:0];
            if (!st_q.lock) begin
                st_d.act  = act_e'(wdata[ACT_BIT]);
                st_d.lock = 1'b1;
            end
            if (wdata[EN_BIT]) begin
                st_d.active = 1'b1;
                if (!st_q.active) clear = 1'b1;
            end
            if (wdata[1:0] != st_q.sel) clear = 1'b1;
        end
        if (wr_cmd) begin
            if (wdata == CMD_CLEAR) clear = 1'b1;
            if (wdata == CMD_DISABLE && !st_q.en) st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{en: 1'b1, act: ACT_RESET, lock: 1'b0, sel: 2'b00, active: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata  = (addr == ADDR_W'(CTRL_OFS)) ?
                    {4'b0000, st_q.en, st_q.act, st_q.sel} : 8'h00;
    assign en     = st_q.en;
    assign act    = st_q.act;
    assign sel    = st_q.sel;
    assign active = st_q.active;

    // R4
    act_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> $stable(st_q.act));

    // R8
    en_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.en |-> st_q.active);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int HI_MAX = 23,
    parameter int LO_MAX = 15,
    parameter int CNT_W  = HI_MAX
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic [1:0] sel,
    input  logic       slow_mode,
    input  logic       slow_tick,
    input  logic       clear,
    output logic       ovf
);

    localparam int NTAP = 4;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             src;
    } cnt_s;

    cnt_s st_d, st_q;
    logic [CNT_W-1:0] hi_top [NTAP];
    logic [CNT_W-1:0] lo_top [NTAP];
    logic [CNT_W-1:0] top;
    logic             restart, step;

    for (genvar g = 0; g < NTAP; g++) begin : g_tap
        localparam int HS = HI_MAX - 2 * g;
        localparam int LS = LO_MAX - 2 * g;
        assign hi_top[g] = CNT_W'((64'd1 << HS) - 64'd1);
        assign lo_top[g] = CNT_W'((64'd1 << LS) - 64'd1);
    end

    always_comb begin
        top     = slow_mode ? lo_top[sel] : hi_top[sel];
        restart = clear || !active || (slow_mode != st_q.src);
        step    = slow_mode ? slow_tick : 1'b1;
        st_d     = st_q;
        st_d.src = slow_mode;
        ovf      = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
        end else if (step) begin
            if (st_q.cnt >= top) begin
                st_d.cnt = '0;
                ovf      = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, src: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (st_q.cnt == '0));

    // R8
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (st_q.cnt == '0));

endmodule

// File: rtl/wdog_action.sv
module wdog_action
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  act_e act,
    input  logic irq_ack,
    output logic rst_req,
    output logic irq
);

    typedef struct packed {
        logic rst_req;
        logic irq;
    } out_s;

    out_s st_d, st_q;

    always_comb begin
        st_d.rst_req = ovf && (act == ACT_RESET);
        st_d.irq     = (st_q.irq && !irq_ack) || (ovf && (act == ACT_IRQ));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_req = st_q.rst_req;
    assign irq     = st_q.irq;

    // R5
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst_req |=> !st_q.rst_req);

    // R6
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && !irq_ack) |=> st_q.irq);

    // R5
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_RESET) |=> !$rose(st_q.irq));

endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int         HI_MAX   = 23,
    parameter int         LO_MAX   = 15,
    parameter logic [7:0] CTRL_OFS = 8'h34,
    parameter logic [7:0] CMD_OFS  = 8'h35
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slow_mode,
    input  logic       slow_tick,
    input  logic       bus_we,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       irq_ack,
    output logic       wdt_rst_req,
    output logic       wdt_irq
);

    localparam int CNT_W = HI_MAX;

    logic       en, active, clear, ovf;
    act_e       act;
    logic [1:0] sel;

    wdog_regs #(
        .ADDR_W   (8),
        .CTRL_OFS (CTRL_OFS),
        .CMD_OFS  (CMD_OFS)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .en     (en),
        .act    (act),
        .sel    (sel),
        .active (active),
        .clear  (clear)
    );

    wdog_counter #(
        .HI_MAX (HI_MAX),
        .LO_MAX (LO_MAX),
        .CNT_W  (CNT_W)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .sel       (sel),
        .slow_mode (slow_mode),
        .slow_tick (slow_tick),
        .clear     (clear),
        .ovf       (ovf)
    );

    wdog_action u_action (
        .clk     (clk),
        .rst_n   (rst_n),
        .ovf     (ovf),
        .act     (act),
        .irq_ack (irq_ack),
        .rst_req (wdt_rst_req),
        .irq     (wdt_irq)
    );

    // R8
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !en) |=> !$rose(wdt_rst_req));

endmodule

// File: tb/wdog_top_bench.sv
`timescale 1ns/1ps
module wdog_top_bench;

    localparam int HI = 9;
    localparam int LO = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_mode = 1'b0, slow_tick = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = 8'h34, bus_wdata = 8'h00;
    logic       irq_ack = 1'b0;
    logic [7:0] bus_rdata;
    logic       wdt_rst_req, wdt_irq;

    int    n_chk = 0, n_fail = 0;
    bit    done = 0;
    bit    mdl_on = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    wdog_top #(.HI_MAX(HI), .LO_MAX(LO)) u_wdog_top (
        .clk(clk), .rst_n(rst_n), .slow_mode(slow_mode), .slow_tick(slow_tick),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_ack(irq_ack),
        .wdt_rst_req(wdt_rst_req), .wdt_irq(wdt_irq));

    // reference model state
    bit       m_en, m_act, m_lock, m_active, m_src, m_rst, m_irq;
    bit [1:0] m_sel;
    int       m_cnt;

    function automatic int exp_top(bit slow, bit [1:0] s);
        return (1 << ((slow ? LO : HI) - 2 * s)) - 1;
    endfunction

    function automatic bit [7:0] exp_rd(bit [7:0] a);
        return (a == 8'h34) ? {4'b0, m_en, m_act, m_sel} : 8'h00;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 1; m_act = 0; m_lock = 0; m_sel = 0; m_active = 1;
            m_src = 0; m_rst = 0; m_irq = 0; m_cnt = 0;
        end else begin
            bit w1, w2, clr, ovf, n_active;
            w1 = bus_we && bus_addr == 8'h34;
            w2 = bus_we && bus_addr == 8'h35;
            clr = (w2 && bus_wdata == 8'h4E) ||
                  (w1 && bus_wdata[1:0] != m_sel) ||
                  (w1 && bus_wdata[3] && !m_active);
            n_active = m_active;
            if (w1 && bus_wdata[3]) n_active = 1;
            if (w2 && bus_wdata == 8'hB1 && !m_en) n_active = 0;
            ovf = 0;
            if (clr || !m_active || slow_mode != m_src) m_cnt = 0;
            else if (!slow_mode || slow_tick) begin
                if (m_cnt >= exp_top(slow_mode, m_sel)) begin m_cnt = 0; ovf = 1; end
                else m_cnt++;
            end
            m_src = slow_mode;
            m_irq = (m_irq && !irq_ack) || (ovf && m_act);
            m_rst = ovf && !m_act;
            if (w1) begin
                m_en = bus_wdata[3]; m_sel = bus_wdata[1:0];
                if (!m_lock) begin m_act = bus_wdata[2]; m_lock = 1; end
            end
            m_active = n_active;
        end
    end

    task automatic chk(bit ok, string req, int act_v, int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act_v, exp_v);
        end
    endtask

    // cycle-by-cycle comparison against the model, away from the edge
    always @(posedge clk) begin
        #1;
        if (mdl_on && rst_n) begin
            chk(wdt_rst_req == m_rst, {cur_req, " rst_req"}, wdt_rst_req, m_rst);
            chk(wdt_irq == m_irq, {cur_req, " irq"}, wdt_irq, m_irq);
            chk(bus_rdata == exp_rd(bus_addr), {cur_req, " rdata"}, bus_rdata, exp_rd(bus_addr));
        end
    end

    task automatic drive(bit we, bit [7:0] a, bit [7:0] d);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, 8'h34, 8'h00);
    endtask

    task automatic wr(bit [7:0] a, bit [7:0] d);
        drive(1, a, d);
        drive(0, 8'h34, 8'h00);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; bus_we = 0; irq_ack = 0; slow_mode = 0; slow_tick = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    // spacing between two rst_req pulses with idle bus
    task automatic measure(int exp_gap, string req);
        int gap = 0, guard = 0;
        bus_we = 0;
        while (!wdt_rst_req && guard < 4000) begin @(posedge clk); #1; guard++; end
        @(posedge clk); #1;
        chk(!wdt_rst_req, {req, " pulse width"}, wdt_rst_req, 0);
        gap = 1;
        while (!wdt_rst_req && gap < 4000) begin @(posedge clk); #1; gap++; end
        chk(gap == exp_gap, {req, " period"}, gap, exp_gap);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog timeout actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7781));
        do_reset();
        mdl_on = 1;
        @(posedge clk); #1;
        // R1 and R10: reset readback and outputs
        chk(bus_rdata == 8'h08, "R1 reset ctrl", bus_rdata, 8'h08);
        chk(!wdt_rst_req && !wdt_irq, "R1 outputs", {wdt_rst_req, wdt_irq}, 0);
        drive(0, 8'h35, 8'h00);
        @(posedge clk); #1;
        chk(bus_rdata == 8'h00, "R10 cmd reads zero", bus_rdata, 0);

        // R2, R4, R5: lock reset mode, shortest fast period
        cur_req = "R5";
        wr(8'h34, 8'h0B);
        measure(8, "R2 R5 sel3");
        cur_req = "R4";
        wr(8'h34, 8'h0E);
        @(posedge clk); #1;
        chk(bus_rdata == 8'h0A, "R4 action locked", bus_rdata, 8'h0A);
        cur_req = "R9";
        measure(32, "R2 R9 sel2");

        // R7: repeated clear code keeps it quiet; junk ignored
        cur_req = "R7";
        wr(8'h35, 8'h4E);
        for (int i = 0; i < 8; i++) begin
            idle(10); wr(8'h35, 8'h55); wr(8'h35, 8'h4E);
        end
        // R8: disable code with enable set is ignored; enable clear alone keeps running
        cur_req = "R8";
        wr(8'h35, 8'hB1);
        measure(32, "R8 still running");
        wr(8'h34, 8'h02);
        measure(32, "R8 enable clear alone");
        wr(8'h35, 8'hB1);
        begin
            bit seen = 0;
            for (int i = 0; i < 200; i++) begin @(posedge clk); #1; if (wdt_rst_req) seen = 1; end
            chk(!seen, "R8 stopped no pulse", seen, 0);
        end
        wr(8'h34, 8'h0B);
        measure(8, "R8 rearm");

        // R3: slow source, sel3 gives 2 ticks
        cur_req = "R3";
        slow_mode = 1;
        for (int i = 0; i < 60; i++) begin
            drive(0, 8'h34, 8'h00); slow_tick = (i % 3 == 0);
        end
        slow_tick = 0; slow_mode = 0;
        idle(20);

        // R6: interrupt mode after fresh reset
        do_reset();
        cur_req = "R6";
        wr(8'h34, 8'h0F);
        idle(12);
        @(posedge clk); #1;
        chk(wdt_irq == 1, "R6 irq set", wdt_irq, 1);
        wr(8'h34, 8'h0B);
        @(posedge clk); #1;
        chk(bus_rdata == 8'h0F, "R4 irq locked", bus_rdata, 8'h0F);
        for (int i = 0; i < 40; i++) begin
            drive(0, 8'h34, 8'h00); irq_ack = (i % 5 == 0);
        end
        irq_ack = 0;

        // random mixed phase
        for (int r = 0; r < 6; r++) begin
            do_reset();
            cur_req = "R2 R3 R4 R5 R6 R7 R8 R9";
            wr(8'h34, 8'($urandom) | 8'h08);
            for (int i = 0; i < 1500; i++) begin
                int p = $urandom_range(0, 99);
                @(negedge clk);
                bus_we = 0; bus_addr = 8'h34;
                if (p < 6) begin bus_we = 1; bus_wdata = 8'($urandom); bus_wdata[3] = ($urandom_range(0, 3) != 0); end
                else if (p < 10) begin bus_we = 1; bus_addr = 8'h35; bus_wdata = 8'h4E; end
                else if (p < 13) begin bus_we = 1; bus_addr = 8'h35; bus_wdata = 8'hB1; end
                else if (p < 16) begin bus_we = 1; bus_addr = 8'h35; bus_wdata = 8'($urandom); end
                else if (p < 18) bus_addr = 8'h35;
                irq_ack = ($urandom_range(0, 9) < 2);
                slow_tick = ($urandom_range(0, 2) == 0);
                if ($urandom_range(0, 299) == 0) slow_mode = ~slow_mode;
            end
        end
        idle(5);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule